// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider with Eight-Phase Tap Selection

This block is the digital feedback divider of a carrier recovery loop. It divides its single clock input, which stands in for the oscillator, by 152 in two cascaded stages. The first stage reaches a ratio of 19 by running a 4/5 dual-modulus prescaler under a small control counter. Every group of four prescaler cycles holds three long cycles of five clocks followed by one short cycle of four clocks.

Each completed group of 19 clocks advances a synchronous divide-by-8 stage. This stage is an eight-bit rotating ring that holds four adjacent ones. Each ring bit is exported as one phase of a square wave with period 152 clocks. Phase k lags phase k-1 by one ring step of 19 clocks, which is 45 degrees. The whole bus goes out for symbol sampling. A three-bit select picks one phase and drives it onto the phase-detector output. The select is taken in only when the ring completes a full turn, so the chosen tap never moves in the middle of a period.

Top module: `dual_mod_phase_divider`

## Requirements
- R1: Every phase is a square wave with a period of 152 clocks, high for 76 clocks and low for 76.
- R2: The phase bus changes only on the clock edge that ends each group of 19 clocks. After reset is released, the first change happens on the 19th rising edge.
- R3: Within each group of 19 clocks, the prescaler runs three cycles of 5 clocks and then one cycle of 4 clocks.
- R4: The phase bus always holds exactly four ones in adjacent bit positions, counted cyclically. Each step moves the block of ones up by one bit, with bit 7 wrapping to bit 0. Bit k of `phases_o` is phase k.
- R5: `pd_o` equals bit `sel_q` of `phases_o`, where `sel_q` is the registered select value and a select value k picks bit k.
- R6: `sel_q` loads `sel_i` only on the edge at which the ring completes its eighth step, which is every 152 clocks. A change of `sel_i` at any other time has no effect on `pd_o`.
- R7: While `rst_n` is low, the block clears on each rising edge: `phases_o` becomes 8'h0F, `sel_q` becomes 0 and `pd_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 3 | Requested phase index for the detector output |
| phases_o | output | 8 | Eight phases, bit k is phase k |
| pd_o | output | 1 | Selected phase routed to the phase detector |

## Verification
The assertions assume that reset is held low for at least one rising edge before the first checked cycle. Their $past terms therefore always see cleared counters. They also assume that `sel_i` is a plain synchronous input that settles away from the clock edge. The stimulus drives reset and `sel_i` only on falling edges and opens each run with several reset cycles. It changes `sel_i` both on and off the 152-clock boundary, which exercises both the ignored path and the loaded path of the select register.

// File: rtl/dmd_pkg.sv
// Package: shared defaults and derived quantities for the divider chain.
// Assumes: the caller keeps SWALLOW below PROG_LEN and NPH a power of two.
package dmd_pkg;

    localparam int unsigned PRE_LOW_DEF  = 4;
    localparam int unsigned PROG_LEN_DEF = 4;
    localparam int unsigned SWALLOW_DEF  = 3;
    localparam int unsigned NPH_DEF      = 8;

    // Clocks in one first-stage period: every prescaler cycle counts LOW, swallow cycles add one.
    function automatic int unsigned first_ratio(input int unsigned low,
                                                input int unsigned len,
                                                input int unsigned sw);
        return low * len + sw;
    endfunction

endpackage

// File: rtl/dmd_prescaler.sv
// Module: dual-modulus prescaler. Divides clk by LOW+1 when mod_hi is set, else by LOW.
// Assumes: mod_hi is constant within a prescaler cycle (it changes only after done).
module dmd_prescaler #(
    parameter int unsigned LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi,
    output logic done
);
    localparam int unsigned CW = $clog2(LOW + 1);
    localparam logic [CW-1:0] LAST_LO = CW'(LOW - 1);
    localparam logic [CW-1:0] LAST_HI = CW'(LOW);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Terminal count picked by the modulus control.
    always_comb last = mod_hi ? LAST_HI : LAST_LO;

    // End-of-cycle strobe.
    always_comb done = (cnt_q == last);

    // Cycle counter, restarts after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (done) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end

    // R3: the counter never runs past the long-cycle terminal value.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_HI);

endmodule

// File: rtl/dmd_swallow_ctrl.sv
// Module: modulus control for the pulse-swallow stage. Counts prescaler cycles,
// requests the long modulus for the first SWALLOW of every PROG_LEN cycles, and
// emits a one-clock tick at the end of each full first-stage period.
// Assumes: pre_done comes from a prescaler driven by this block's mod_hi.
module dmd_swallow_ctrl #(
    parameter int unsigned PROG_LEN = 4,
    parameter int unsigned SWALLOW  = 3,
    parameter int unsigned LOW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_done,
    output logic mod_hi,
    output logic tick
);
    localparam int unsigned IW    = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
    localparam int unsigned RATIO = dmd_pkg::first_ratio(LOW, PROG_LEN, SWALLOW);
    localparam int unsigned LW    = $clog2(LOW + 2);
    localparam int unsigned PW    = $clog2(RATIO + 1);
    localparam logic [IW-1:0] SW_L   = IW'(SWALLOW);
    localparam logic [IW-1:0] LAST_I = IW'(PROG_LEN - 1);

    logic [IW-1:0] idx_q;

    // Long modulus during the swallow cycles of the group.
    always_comb mod_hi = (idx_q < SW_L);

    // Tick when the final prescaler cycle of the group ends.
    always_comb tick = pre_done && (idx_q == LAST_I);

    // Prescaler cycle index within the group.
    always_ff @(posedge clk) begin
        if (!rst_n)             idx_q <= '0;
        else if (tick)          idx_q <= '0;
        else if (pre_done)      idx_q <= idx_q + IW'(1);
    end

    // Checker state: clocks spent in the current prescaler cycle and since the last tick.
    logic [LW-1:0] len_q;
    logic [PW-1:0] per_q;

    // Clock-count observers used only by the assertions below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            per_q <= '0;
        end else begin
            len_q <= pre_done ? '0 : len_q + LW'(1);
            per_q <= tick     ? '0 : per_q + PW'(1);
        end
    end

    // R3: swallow cycles last LOW+1 clocks, the rest LOW clocks.
    a_r3_sub_len: assert property (@(posedge clk) disable iff (!rst_n)
        pre_done |-> (int'(len_q) == ((idx_q < SW_L) ? int'(LOW) : int'(LOW) - 1)));

    // R2: ticks are spaced by exactly RATIO clocks.
    a_r2_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (int'(per_q) == int'(RATIO) - 1));

endmodule

// File: rtl/dmd_phase_ring.sv
// Module: synchronous divide-by-NPH ring. Holds NPH/2 adjacent ones that rotate
// one place per tick; each bit is one output phase, bit k lagging bit k-1 by one tick.
// Assumes: tick is a single-clock strobe.
module dmd_phase_ring #(
    parameter int unsigned NPH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    output logic [NPH-1:0] phases,
    output logic           wrap
);
    localparam int unsigned PW   = $clog2(NPH);
    localparam int unsigned HALF = NPH / 2;
    localparam logic [NPH-1:0] SEED = {{(NPH-HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [PW-1:0]  LAST_P = PW'(NPH - 1);

    logic [NPH-1:0] ring_q;
    logic [PW-1:0]  pos_q;

    // Ring rotation and step position, both advanced on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= SEED;
            pos_q  <= '0;
        end else if (tick) begin
            ring_q <= {ring_q[NPH-2:0], ring_q[NPH-1]};
            pos_q  <= pos_q + PW'(1);
        end
    end

    // Full-turn boundary: the step that returns the ring to its seed.
    always_comb wrap = tick && (pos_q == LAST_P);

    // One output per ring bit.
    for (genvar g = 0; g < NPH; g++) begin : g_tap
        assign phases[g] = ring_q[g];
    end

    // R4: exactly half of the phases are high at all times.
    a_r4_half_high: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring_q) == HALF);

    // R2: the bus holds between ticks.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(ring_q));

    // R1: after a full turn the ring is back at its seed pattern.
    a_r1_turn_seed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> (ring_q == SEED));

endmodule

// File: rtl/dmd_phase_pick.sv
// Module: phase selector. Registers the requested index at each full-turn boundary
// and routes that phase to the detector output.
// Assumes: wrap marks the edge at which the ring returns to its seed.
module dmd_phase_pick #(
    parameter int unsigned NPH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wrap,
    input  logic [$clog2(NPH)-1:0] sel_i,
    input  logic [NPH-1:0]         phases,
    output logic                   pd_o
);
    localparam int unsigned SW = $clog2(NPH);

    logic [SW-1:0] sel_q;

    // Select register, loaded only on the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= '0;
        else if (wrap) sel_q <= sel_i;
    end

    // Route the chosen phase.
    always_comb pd_o = phases[sel_q];

    // R6: the selection holds away from the boundary.
    a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> $stable(sel_q));

    // R6: on the boundary the request is taken in.
    a_r6_sel_take: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> (sel_q == $past(sel_i)));

endmodule

// File: rtl/dual_mod_phase_divider.sv
// Module: top of the feedback divider chain. Prescaler plus modulus control form
// the first stage (ratio LOW*LEN+SWALLOW); a ring forms the NPH-phase second stage;
// a selector routes one phase to the detector output.
// Assumes: synchronous active-low reset held for at least one clock.
module dual_mod_phase_divider #(
    parameter int unsigned PRE_LOW  = dmd_pkg::PRE_LOW_DEF,
    parameter int unsigned PROG_LEN = dmd_pkg::PROG_LEN_DEF,
    parameter int unsigned SWALLOW  = dmd_pkg::SWALLOW_DEF,
    parameter int unsigned NPH      = dmd_pkg::NPH_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(NPH)-1:0] sel_i,
    output logic [NPH-1:0]         phases_o,
    output logic                   pd_o
);
    logic mod_hi;
    logic pre_done;
    logic tick;
    logic wrap;

    dmd_prescaler #(.LOW(PRE_LOW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_hi (mod_hi),
        .done   (pre_done)
    );

    dmd_swallow_ctrl #(.PROG_LEN(PROG_LEN), .SWALLOW(SWALLOW), .LOW(PRE_LOW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_done (pre_done),
        .mod_hi   (mod_hi),
        .tick     (tick)
    );

    dmd_phase_ring #(.NPH(NPH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .phases (phases_o),
        .wrap   (wrap)
    );

    dmd_phase_pick #(.NPH(NPH)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .sel_i  (sel_i),
        .phases (phases_o),
        .pd_o   (pd_o)
    );

    // R2: a second-stage boundary only ever coincides with a first-stage tick.
    a_r2_wrap_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> tick);

endmodule

// File: tb/dual_mod_phase_divider_test.sv
// Scoreboard bench: the driver pushes the expected outputs for each coming edge,
// and the monitor pops and compares a quarter period after the edge.
module dual_mod_phase_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int RATIO      = 19;
    localparam int NPH        = 8;
    localparam int FULL       = RATIO * NPH;

    typedef struct {
        logic [7:0] bus;
        logic       pd;
        int         kind;   // 0 normal, 1 reset, 2 select request pending
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_i = 3'd0;
    logic [7:0] phases_o;
    logic       pd_o;

    exp_t q[$];
    int   n_mdl = 0;
    int   selq_mdl = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    dual_mod_phase_divider uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .phases_o (phases_o),
        .pd_o     (pd_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: drive inputs on the falling edge and queue the outputs expected after the next rising edge.
    task automatic step(input logic rst_v, input logic [2:0] s);
        exp_t e;
        int   p;
        @(negedge clk);
        rst_n = rst_v;
        sel_i = s;
        if (!rst_v) begin
            n_mdl = 0;
            selq_mdl = 0;
            e.kind = 1;
        end else begin
            if ((n_mdl % FULL) == FULL - 1) selq_mdl = s;
            n_mdl++;
            e.kind = (int'(s) != selq_mdl) ? 2 : 0;
        end
        p = (n_mdl / RATIO) % NPH;
        for (int k = 0; k < NPH; k++) e.bus[k] = (((k - p + NPH) % NPH) < 4);
        e.pd = e.bus[selq_mdl];
        q.push_back(e);
    endtask

    task automatic run(input int cnt, input logic [2:0] s);
        for (int i = 0; i < cnt; i++) step(1'b1, s);
    endtask

    // Monitor: compare against the scoreboard and measure phase 0 timing.
    int  mon_n = 0;
    bit  first_move_seen = 1'b0;
    bit  rise_seen = 1'b0;
    int  hi_run = 0;
    int  last_rise = -1;
    logic prev_p0 = 1'b0;

    always @(posedge clk) begin
        exp_t e;
        #(CLK_PERIOD/4);
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (phases_o !== e.bus) begin
                fails++;
                if (e.kind == 1) $display("FAIL R7 reset phase bus: got %h expected %h", phases_o, e.bus);
                else $display("FAIL R2/R4 phase bus at edge %0d: got %h expected %h", mon_n + 1, phases_o, e.bus);
            end
            checks++;
            if (pd_o !== e.pd) begin
                fails++;
                if (e.kind == 1) $display("FAIL R7 reset pd_o: got %b expected %b", pd_o, e.pd);
                else if (e.kind == 2) $display("FAIL R6 pd_o with pending select: got %b expected %b", pd_o, e.pd);
                else $display("FAIL R5 pd_o: got %b expected %b", pd_o, e.pd);
            end
        end
        if (!rst_n) begin
            mon_n = 0;
            first_move_seen = 1'b0;
            rise_seen = 1'b0;
            hi_run = 0;
            last_rise = -1;
        end else begin
            mon_n++;
            // R2 R3: the first step of the bus lands on edge 19 (three 5-clock plus one 4-clock cycle).
            if (!first_move_seen && phases_o !== 8'h0F) begin
                first_move_seen = 1'b1;
                checks++;
                if (mon_n != RATIO) begin
                    fails++;
                    $display("FAIL R3 first bus step at edge: got %0d expected %0d", mon_n, RATIO);
                end
            end
            // R1: high time and period of phase 0.
            if (phases_o[0] && !prev_p0) begin
                if (last_rise >= 0) begin
                    checks++;
                    if (mon_n - last_rise != FULL) begin
                        fails++;
                        $display("FAIL R1 period: got %0d expected %0d", mon_n - last_rise, FULL);
                    end
                end
                last_rise = mon_n;
                rise_seen = 1'b1;
                hi_run = 0;
            end
            if (phases_o[0]) hi_run++;
            if (!phases_o[0] && prev_p0 && rise_seen) begin
                checks++;
                if (hi_run != FULL / 2) begin
                    fails++;
                    $display("FAIL R1 high time: got %0d expected %0d", hi_run, FULL / 2);
                end
            end
        end
        prev_p0 = phases_o[0];
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 4; i++) step(1'b0, 3'd0);          // R7 reset state
        run(200, 3'd0);                                         // R2 R3 R4 base pattern
        run(100, 3'd3);                                         // R6 request mid-frame, ignored until edge 304
        run(200, 3'd3);                                         // R6 load at boundary, R5 on tap 3
        for (int s = 0; s < 8; s++) run(190, 3'(s));            // R5 every tap, R6 off-boundary changes
        run(160, 3'd5);                                         // R1 long steady run
        for (int i = 0; i < 3; i++) step(1'b0, 3'd2);           // R7 reset mid-run
        run(400, 3'd6);                                         // R2 R6 restart after reset
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule